// File: doc/BRIEF.md
# Four-level radix page table walker

This block resolves one address translation miss at a time. It reads a radix page table of four levels held in memory. A miss request carries a 48-bit virtual address, the write and user attributes of the access, and a root register. Bits 51:12 of the root register give the frame of the top table, and bits 11:0 give a process-context tag that is echoed with the result. The walker issues one 8-byte read per level through a memory port with a single outstanding request. It checks each returned entry and moves down the tree one level at a time.

A walk ends in one of two ways. It can pulse a fill result carrying the frame number, the page size and the permissions combined across the path, ready for a TLB fill. It can instead pulse a fault carrying an error code and the faulting virtual address. If an entry on the path has its Accessed bit clear, the walker updates that entry in memory with a locked read-modify-write before it goes on. On a write access it also sets the Dirty bit of the leaf. A 2 MB leaf at the third level ends the walk early.

Top module: `ptw_walker`

## Requirements
- R1: After reset, miss_ready is 1 and mem_req_valid, fill_valid and fault_valid are 0.
- R2: The first read goes to address (root[51:12] << 12) + VA[47:39]*8. The fill returns root[11:0] on fill_pcid and VA[47:12] on fill_vpn.
- R3: Levels are read in strict sequence. The next level's read goes to (entry[51:12] << 12) + index*8, where the index is VA[38:30], then VA[29:21], then VA[20:12]. It is issued only after the previous entry has returned. A request stays valid with a stable address until mem_req_ready accepts it.
- R4: An entry whose present bit (bit 0) is 0 ends the walk with a fault, and no further memory request is made. Error code bit 0 is 0 in this case.
- R5: A present entry with reserved bits set faults with error code bits 3 and 0 both set. Reserved bits are: entry bits 51:46; bit 7 at the top or second level; bits 20:13 of a 2 MB leaf.
- R6: When a traversed entry has Accessed (bit 5) clear, the walker issues a locked read (lock=1, write=0) of that entry. It follows this with a locked write (lock=1, write=1) of the value read with bit 5 set, before any read of the next level. Every write request is locked.
- R7: On a write access whose leaf has Dirty (bit 6) clear, the same locked update also sets bit 6. A read access never sets bit 6, and never updates an entry whose Accessed bit is already set.
- R8: A third-level entry with bit 7 set is a 2 MB leaf. The walk then makes three reads, and the fill has fill_large=1 and fill_pfn = {entry[51:21], VA[20:12]}. A 4 KB leaf gives fill_pfn = entry[51:12] and fill_large=0.
- R9: fill_writable is the AND of bit 1 along the path, and fill_user is the AND of bit 2 along the path. fill_nx is the OR of bit 63 along the path. fill_global is bit 8 of the leaf.
- R10: Error code bit 1 equals the access's write flag and bit 2 equals its user flag. fault_va returns the full faulting virtual address.
- R11: fill_valid and fault_valid are one-cycle pulses that never occur together. After either pulse the walker is ready for a new miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle and accepting a miss |
| miss_va | input | 48 | Virtual address to translate |
| miss_root | input | 52 | Root register: table frame in 51:12, context tag in 11:0 |
| miss_write | input | 1 | Access is a write |
| miss_user | input | 1 | Access is from user mode |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 52 | Physical byte address of the entry |
| mem_req_write | output | 1 | Request is a write |
| mem_req_lock | output | 1 | Request belongs to a locked read-modify-write |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | 64 | Read data (ignored for writes) |
| fill_valid | output | 1 | Translation result pulse |
| fill_vpn | output | 36 | Virtual page number of the miss |
| fill_pfn | output | 40 | Physical frame number |
| fill_pcid | output | 12 | Context tag from the root register |
| fill_large | output | 1 | 2 MB page |
| fill_writable | output | 1 | Combined write permission |
| fill_user | output | 1 | Combined user permission |
| fill_nx | output | 1 | Combined no-execute |
| fill_global | output | 1 | Global mapping |
| fault_valid | output | 1 | Page fault pulse |
| fault_code | output | 4 | Bit 0 present, 1 write, 2 user, 3 reserved |
| fault_va | output | 48 | Faulting virtual address |

## Verification
The bench targets four cases. The first is a not-present entry at an inner level: a walker that kept going would issue a read using that entry's stale address. The second is an entry with Accessed clear at a middle level: a walker without the update, or one that set the bit with a plain unlocked write, shows the wrong request sequence or leaves memory unchanged. The third is a write to a leaf with Dirty clear, set beside a read to the same leaf: a walker that ignored the access type would either skip the Dirty update or set the bit on reads. The fourth covers the 2 MB leaf and reserved bits at several levels: a walker that missed the early end would issue a fourth read and return the wrong frame, and one that skipped the reserved check would return a fill where a fault with bit 3 is due.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ENTRY_W = 64;
  localparam int BIT_P   = 0;
  localparam int BIT_RW  = 1;
  localparam int BIT_US  = 2;
  localparam int BIT_A   = 5;
  localparam int BIT_D   = 6;
  localparam int BIT_PS  = 7;
  localparam int BIT_G   = 8;
  localparam int BIT_NX  = 63;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE,
    S_READ,
    S_CHECK,
    S_LKRD,
    S_LKWR,
    S_NEXT
  } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int LEVELS     = 4,
  parameter int IDX_W      = 9,
  parameter int PAGE_SHIFT = 12,
  parameter int PA_W       = 52,
  localparam int VA_W      = PAGE_SHIFT + LEVELS * IDX_W,
  localparam int LVL_W     = $clog2(LEVELS),
  localparam int FRAME_W   = PA_W - PAGE_SHIFT
) (
  input  logic [FRAME_W-1:0] base_i,
  input  logic [VA_W-1:0]    va_i,
  input  logic [LVL_W-1:0]   lvl_i,
  output logic [PA_W-1:0]    addr_o
);
  localparam int ENT_SH = PAGE_SHIFT - IDX_W;

  logic [IDX_W-1:0] idx_arr [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idx_arr[l] = va_i[PAGE_SHIFT + IDX_W*l +: IDX_W];
  end

  assign addr_o = {base_i, idx_arr[lvl_i], {ENT_SH{1'b0}}};
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import ptw_pkg::*;
#(
  parameter int LEVELS     = 4,
  parameter int IDX_W      = 9,
  parameter int PAGE_SHIFT = 12,
  parameter int PA_W       = 52,
  parameter int PHYS_W     = 46,
  localparam int LVL_W     = $clog2(LEVELS)
) (
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic [LVL_W-1:0]   lvl_i,
  input  logic               write_i,
  output logic               present_o,
  output logic               rsvd_o,
  output logic               leaf_o,
  output logic [ENTRY_W-1:0] set_mask_o,
  output logic               needs_upd_o
);
  localparam logic [LVL_W-1:0] LARGE_LVL = LVL_W'(1);
  localparam logic [LVL_W-1:0] LEAF_LVL  = LVL_W'(0);
  localparam int LG_HI = PAGE_SHIFT + IDX_W - 1;
  localparam int LG_LO = PAGE_SHIFT + 1;

  logic big_page;
  logic addr_rsvd;
  logic ps_rsvd;
  logic large_rsvd;

  assign big_page   = entry_i[BIT_PS];
  assign addr_rsvd  = |entry_i[PA_W-1:PHYS_W];
  assign ps_rsvd    = big_page && (lvl_i > LARGE_LVL);
  assign large_rsvd = big_page && (lvl_i == LARGE_LVL) && (|entry_i[LG_HI:LG_LO]);

  assign present_o = entry_i[BIT_P];
  assign rsvd_o    = addr_rsvd || ps_rsvd || large_rsvd;
  assign leaf_o    = (lvl_i == LEAF_LVL) || ((lvl_i == LARGE_LVL) && big_page);

  always_comb begin
    set_mask_o = '0;
    set_mask_o[BIT_A] = 1'b1;
    set_mask_o[BIT_D] = leaf_o && write_i;
  end

  assign needs_upd_o = (entry_i & set_mask_o) != set_mask_o;
endmodule

// File: rtl/ptw_perm_acc.sv
module ptw_perm_acc (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic step_i,
  input  logic rw_i,
  input  logic us_i,
  input  logic nx_i,
  output logic rw_o,
  output logic us_o,
  output logic nx_o
);
  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      rw_o <= 1'b1;
      us_o <= 1'b1;
      nx_o <= 1'b0;
    end else if (step_i) begin
      rw_o <= rw_o & rw_i;
      us_o <= us_o & us_i;
      nx_o <= nx_o | nx_i;
    end
  end

  // R9: within a walk a permission can only be removed, never restored
  p_rw_monotone_r9: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> !$rose(rw_o));
  p_nx_monotone_r9: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> !$fell(nx_o));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int LEVELS     = 4,
  parameter int IDX_W      = 9,
  parameter int PAGE_SHIFT = 12,
  parameter int PA_W       = 52,
  parameter int PHYS_W     = 46,
  localparam int VA_W      = PAGE_SHIFT + LEVELS * IDX_W,
  localparam int FRAME_W   = PA_W - PAGE_SHIFT,
  localparam int VPN_W     = VA_W - PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [VA_W-1:0]    miss_va,
  input  logic [PA_W-1:0]    miss_root,
  input  logic               miss_write,
  input  logic               miss_user,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  output logic               mem_req_write,
  output logic               mem_req_lock,
  output logic [ENTRY_W-1:0] mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               fill_valid,
  output logic [VPN_W-1:0]   fill_vpn,
  output logic [FRAME_W-1:0] fill_pfn,
  output logic [PAGE_SHIFT-1:0] fill_pcid,
  output logic               fill_large,
  output logic               fill_writable,
  output logic               fill_user,
  output logic               fill_nx,
  output logic               fill_global,
  output logic               fault_valid,
  output logic [3:0]         fault_code,
  output logic [VA_W-1:0]    fault_va
);
  localparam int LVL_W = $clog2(LEVELS);
  localparam int LG_SH = PAGE_SHIFT + IDX_W;

  walk_state_e state_q;
  logic [VA_W-1:0]       va_q;
  logic                  write_q;
  logic                  user_q;
  logic [PAGE_SHIFT-1:0] pcid_q;
  logic [FRAME_W-1:0]    base_q;
  logic [LVL_W-1:0]      lvl_q;
  logic [ENTRY_W-1:0]    entry_q;

  logic [PA_W-1:0]    next_addr;
  logic               chk_present;
  logic               chk_rsvd;
  logic               chk_leaf;
  logic [ENTRY_W-1:0] chk_mask;
  logic               chk_upd;
  logic               acc_rw;
  logic               acc_us;
  logic               acc_nx;
  logic               walk_start;

  assign miss_ready = (state_q == S_IDLE);
  assign walk_start = miss_ready && miss_valid;

  ptw_addr_gen #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT), .PA_W(PA_W)
  ) u_addr (
    .base_i (base_q),
    .va_i   (va_q),
    .lvl_i  (lvl_q),
    .addr_o (next_addr)
  );

  ptw_entry_check #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT),
    .PA_W(PA_W), .PHYS_W(PHYS_W)
  ) u_check (
    .entry_i     (entry_q),
    .lvl_i       (lvl_q),
    .write_i     (write_q),
    .present_o   (chk_present),
    .rsvd_o      (chk_rsvd),
    .leaf_o      (chk_leaf),
    .set_mask_o  (chk_mask),
    .needs_upd_o (chk_upd)
  );

  ptw_perm_acc u_perm (
    .clk     (clk),
    .rst     (rst),
    .start_i (walk_start),
    .step_i  (state_q == S_NEXT),
    .rw_i    (entry_q[BIT_RW]),
    .us_i    (entry_q[BIT_US]),
    .nx_i    (entry_q[BIT_NX]),
    .rw_o    (acc_rw),
    .us_o    (acc_us),
    .nx_o    (acc_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= S_IDLE;
      va_q          <= '0;
      write_q       <= 1'b0;
      user_q        <= 1'b0;
      pcid_q        <= '0;
      base_q        <= '0;
      lvl_q         <= '0;
      entry_q       <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_write <= 1'b0;
      mem_req_lock  <= 1'b0;
      mem_req_wdata <= '0;
      fill_valid    <= 1'b0;
      fill_vpn      <= '0;
      fill_pfn      <= '0;
      fill_pcid     <= '0;
      fill_large    <= 1'b0;
      fill_writable <= 1'b0;
      fill_user     <= 1'b0;
      fill_nx       <= 1'b0;
      fill_global   <= 1'b0;
      fault_valid   <= 1'b0;
      fault_code    <= '0;
      fault_va      <= '0;
    end else begin
      fill_valid  <= 1'b0;
      fault_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) mem_req_valid <= 1'b0;

      unique case (state_q)
        S_IDLE: begin
          if (miss_valid) begin
            va_q    <= miss_va;
            write_q <= miss_write;
            user_q  <= miss_user;
            pcid_q  <= miss_root[PAGE_SHIFT-1:0];
            base_q  <= miss_root[PA_W-1:PAGE_SHIFT];
            lvl_q   <= LVL_W'(LEVELS - 1);
            state_q <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          mem_req_valid <= 1'b1;
          mem_req_addr  <= next_addr;
          mem_req_write <= 1'b0;
          mem_req_lock  <= 1'b0;
          state_q       <= S_READ;
        end
        S_READ: begin
          if (mem_rsp_valid && !mem_req_valid) begin
            entry_q <= mem_rsp_data;
            state_q <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (!chk_present || chk_rsvd) begin
            fault_valid <= 1'b1;
            fault_code  <= {chk_present && chk_rsvd, user_q, write_q, chk_present};
            fault_va    <= va_q;
            state_q     <= S_IDLE;
          end else if (chk_upd) begin
            mem_req_valid <= 1'b1;
            mem_req_lock  <= 1'b1;
            mem_req_write <= 1'b0;
            state_q       <= S_LKRD;
          end else begin
            state_q <= S_NEXT;
          end
        end
        S_LKRD: begin
          if (mem_rsp_valid && !mem_req_valid) begin
            entry_q       <= mem_rsp_data;
            mem_req_valid <= 1'b1;
            mem_req_write <= 1'b1;
            mem_req_lock  <= 1'b1;
            mem_req_wdata <= mem_rsp_data | chk_mask;
            state_q       <= S_LKWR;
          end
        end
        S_LKWR: begin
          if (mem_rsp_valid && !mem_req_valid) begin
            entry_q      <= entry_q | chk_mask;
            mem_req_lock <= 1'b0;
            state_q      <= S_NEXT;
          end
        end
        S_NEXT: begin
          if (chk_leaf) begin
            fill_valid    <= 1'b1;
            fill_vpn      <= va_q[VA_W-1:PAGE_SHIFT];
            fill_pcid     <= pcid_q;
            fill_large    <= (lvl_q != '0);
            fill_pfn      <= (lvl_q != '0) ?
                             {entry_q[PA_W-1:LG_SH], va_q[LG_SH-1:PAGE_SHIFT]} :
                             entry_q[PA_W-1:PAGE_SHIFT];
            fill_writable <= acc_rw & entry_q[BIT_RW];
            fill_user     <= acc_us & entry_q[BIT_US];
            fill_nx       <= acc_nx | entry_q[BIT_NX];
            fill_global   <= entry_q[BIT_G];
            state_q       <= S_IDLE;
          end else begin
            base_q  <= entry_q[PA_W-1:PAGE_SHIFT];
            lvl_q   <= lvl_q - LVL_W'(1);
            state_q <= S_ISSUE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R3: a pending request holds its contents until accepted
  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_lock));
  // R6: every memory write is part of a locked update
  p_write_locked_r6: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_write |-> mem_req_lock);
  // R1: an idle walker drives no request
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    miss_ready |-> !mem_req_valid);
  // R11: a walk ends with exactly one kind of result
  p_one_result_r11: assert property (@(posedge clk) disable iff (rst)
    !(fill_valid && fault_valid));
  // R4: after a fault no request follows
  p_fault_stops_r4: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> !mem_req_valid && miss_ready);
  // R11: results are single-cycle pulses
  p_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> !fill_valid);
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [47:0] miss_va = '0;
  logic [51:0] miss_root = '0;
  logic        miss_write = 1'b0;
  logic        miss_user = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [51:0] mem_req_addr;
  logic        mem_req_write;
  logic        mem_req_lock;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        fill_valid;
  logic [35:0] fill_vpn;
  logic [39:0] fill_pfn;
  logic [11:0] fill_pcid;
  logic        fill_large, fill_writable, fill_user, fill_nx, fill_global;
  logic        fault_valid;
  logic [3:0]  fault_code;
  logic [47:0] fault_va;

  always #2.5 clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_va(miss_va),
    .miss_root(miss_root), .miss_write(miss_write), .miss_user(miss_user),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_write(mem_req_write),
    .mem_req_lock(mem_req_lock), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_pcid(fill_pcid), .fill_large(fill_large), .fill_writable(fill_writable),
    .fill_user(fill_user), .fill_nx(fill_nx), .fill_global(fill_global),
    .fault_valid(fault_valid), .fault_code(fault_code), .fault_va(fault_va)
  );

  // memory model: sparse store, two-cycle response, periodic back-pressure
  logic [63:0] mem [logic [51:0]];
  logic [31:0] tick = '0;
  logic [1:0]  dly = '0;
  logic [63:0] pend = '0;
  int          log_n = 0;
  logic [51:0] log_addr [16];
  logic        log_wr   [16];
  logic        log_lk   [16];
  logic [63:0] log_wd   [16];

  assign mem_req_ready = (tick % 3) != 1;

  always @(posedge clk) begin
    tick <= tick + 1;
    mem_rsp_valid <= 1'b0;
    if (rst) begin
      dly <= '0;
    end else begin
      if (dly == 2'd1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= pend;
      end
      if (dly != 0) dly <= dly - 1;
      if (mem_req_valid && mem_req_ready) begin
        if (log_n < 16) begin
          log_addr[log_n] = mem_req_addr;
          log_wr[log_n]   = mem_req_write;
          log_lk[log_n]   = mem_req_lock;
          log_wd[log_n]   = mem_req_wdata;
        end
        log_n = log_n + 1;
        if (mem_req_write) begin
          mem[mem_req_addr] = mem_req_wdata;
          pend <= mem_req_wdata;
        end else begin
          pend <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
        end
        dly <= 2'd2;
      end
    end
  end

  int checks = 0;
  int errors = 0;

  localparam logic [63:0] F_P  = 64'h1;
  localparam logic [63:0] F_RW = 64'h2;
  localparam logic [63:0] F_US = 64'h4;
  localparam logic [63:0] F_A  = 64'h20;
  localparam logic [63:0] F_D  = 64'h40;
  localparam logic [63:0] F_PS = 64'h80;
  localparam logic [63:0] F_G  = 64'h100;
  localparam logic [63:0] F_NX = 64'h8000_0000_0000_0000;
  localparam logic [63:0] F_OK = F_P | F_RW | F_US | F_A;

  localparam logic [8:0]  I3 = 9'h1A3, I2 = 9'h055, I1 = 9'h1FF, I0 = 9'h002;
  localparam logic [47:0] VA = {I3, I2, I1, I0, 12'h345};
  localparam logic [51:0] ROOT = {40'h100, 12'h3C5};
  localparam logic [39:0] FR3 = 40'h100, FR2 = 40'h101, FR1 = 40'h102, FR0 = 40'h103;
  localparam logic [39:0] LEAF = 40'hABCDE;

  logic        got_fill, got_fault;
  logic [39:0] r_pfn;
  logic [35:0] r_vpn;
  logic [11:0] r_pcid;
  logic        r_large, r_wr, r_us, r_nx, r_g;
  logic [3:0]  r_code;
  logic [47:0] r_fva;

  function automatic logic [63:0] mk(input logic [39:0] frame, input logic [63:0] flags);
    return (64'(frame) << 12) | flags;
  endfunction

  function automatic logic [51:0] ea(input logic [39:0] frame, input logic [8:0] idx);
    return (52'(frame) << 12) | (52'(idx) << 3);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic build(input logic [63:0] f3, input logic [63:0] f2,
                       input logic [63:0] f1, input logic [63:0] f0);
    mem.delete();
    mem[ea(FR3, I3)] = mk(FR2, f3);
    mem[ea(FR2, I2)] = mk(FR1, f2);
    mem[ea(FR1, I1)] = mk(FR0, f1);
    mem[ea(FR0, I0)] = mk(LEAF, f0);
  endtask

  task automatic run_walk(input logic wr, input logic usr);
    int t;
    @(negedge clk);
    log_n = 0;
    miss_va = VA; miss_root = ROOT; miss_write = wr; miss_user = usr;
    miss_valid = 1'b1;
    @(negedge clk);
    miss_valid = 1'b0;
    t = 0;
    while (!fill_valid && !fault_valid && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 2000, "R11 walk completes (watchdog)", 64'(t), 64'd2000);
    got_fill = fill_valid; got_fault = fault_valid;
    r_pfn = fill_pfn; r_vpn = fill_vpn; r_pcid = fill_pcid; r_large = fill_large;
    r_wr = fill_writable; r_us = fill_user; r_nx = fill_nx; r_g = fill_global;
    r_code = fault_code; r_fva = fault_va;
    chk(!(got_fill && got_fault), "R11 single result", {62'd0, got_fill, got_fault}, 64'd0);
    @(negedge clk);
    chk(!fill_valid && !fault_valid && miss_ready, "R11 pulse ends, ready again",
        {61'd0, fill_valid, fault_valid, miss_ready}, 64'd1);
  endtask

  task automatic t_reset;
    chk(miss_ready === 1'b1, "R1 miss_ready after reset", 64'(miss_ready), 64'd1);
    chk(!mem_req_valid && !fill_valid && !fault_valid, "R1 outputs quiet after reset",
        {61'd0, mem_req_valid, fill_valid, fault_valid}, 64'd0);
  endtask

  task automatic t_basic_4k;
    build(F_OK, F_OK, F_OK, F_OK | F_D);
    run_walk(1'b0, 1'b1);
    chk(got_fill, "R3 basic walk fills", 64'(got_fill), 64'd1);
    chk(log_n == 4, "R3 four reads", 64'(log_n), 64'd4);
    chk(log_addr[0] == ea(FR3, I3), "R2 first read address", 64'(log_addr[0]), 64'(ea(FR3, I3)));
    chk(log_addr[1] == ea(FR2, I2), "R3 second read address", 64'(log_addr[1]), 64'(ea(FR2, I2)));
    chk(log_addr[2] == ea(FR1, I1), "R3 third read address", 64'(log_addr[2]), 64'(ea(FR1, I1)));
    chk(log_addr[3] == ea(FR0, I0), "R3 fourth read address", 64'(log_addr[3]), 64'(ea(FR0, I0)));
    chk(!log_wr[0] && !log_wr[1] && !log_wr[2] && !log_wr[3] && !log_lk[3], "R7 no update on read",
        {60'd0, log_wr[0], log_wr[1], log_wr[2], log_wr[3]}, 64'd0);
    chk(r_pfn == LEAF && !r_large, "R8 4K frame", 64'(r_pfn), 64'(LEAF));
    chk(r_pcid == 12'h3C5 && r_vpn == VA[47:12], "R2 tag and vpn", {16'd0, r_pcid, r_vpn}, {16'd0, 12'h3C5, VA[47:12]});
    chk(r_wr && r_us && !r_nx && !r_g, "R9 full permissions", {60'd0, r_wr, r_us, r_nx, r_g}, 64'hC);
  endtask

  task automatic t_accessed_update;
    build(F_OK, F_P | F_RW | F_US, F_OK, F_OK | F_D);
    run_walk(1'b0, 1'b0);
    chk(got_fill && log_n == 6, "R6 request count with update", 64'(log_n), 64'd6);
    chk(log_addr[2] == ea(FR2, I2) && log_lk[2] && !log_wr[2], "R6 locked read",
        {log_addr[2], 10'd0, log_lk[2], log_wr[2]}, {ea(FR2, I2), 12'h2});
    chk(log_addr[3] == ea(FR2, I2) && log_lk[3] && log_wr[3] && log_wd[3] == mk(FR1, F_OK),
        "R6 locked write sets A", log_wd[3], mk(FR1, F_OK));
    chk(log_addr[4] == ea(FR1, I1) && !log_lk[4], "R6 next level after update", 64'(log_addr[4]), 64'(ea(FR1, I1)));
    chk(mem[ea(FR2, I2)] == mk(FR1, F_OK), "R6 memory updated", mem[ea(FR2, I2)], mk(FR1, F_OK));
  endtask

  task automatic t_dirty;
    build(F_OK, F_OK, F_OK, F_OK);
    run_walk(1'b0, 1'b0);
    chk(got_fill && log_n == 4, "R7 read leaves D alone", 64'(log_n), 64'd4);
    chk(mem[ea(FR0, I0)] == mk(LEAF, F_OK), "R7 leaf unchanged on read", mem[ea(FR0, I0)], mk(LEAF, F_OK));
    run_walk(1'b1, 1'b0);
    chk(got_fill && log_n == 6, "R7 write triggers update", 64'(log_n), 64'd6);
    chk(log_wr[5] && log_lk[5] && log_wd[5] == mk(LEAF, F_OK | F_D), "R7 D set by write",
        log_wd[5], mk(LEAF, F_OK | F_D));
  endtask

  task automatic t_large;
    build(F_OK, F_OK, F_OK, F_OK);
    mem[ea(FR1, I1)] = mk(40'hABC00, F_OK | F_D | F_PS);
    run_walk(1'b0, 1'b1);
    chk(got_fill && log_n == 3, "R8 2M walk three reads", 64'(log_n), 64'd3);
    chk(r_large && r_pfn == 40'hABC02, "R8 2M frame", 64'(r_pfn), 64'hABC02);
  endtask

  task automatic t_not_present;
    build(F_OK, F_OK, F_RW | F_A, F_OK);
    run_walk(1'b1, 1'b0);
    chk(got_fault && log_n == 3, "R4 stop after not-present", 64'(log_n), 64'd3);
    chk(r_code == 4'b0010, "R10 code for not-present write", 64'(r_code), 64'd2);
    chk(r_fva == VA, "R10 fault address", 64'(r_fva), 64'(VA));
  endtask

  task automatic t_reserved;
    build(F_OK, F_OK, F_OK, F_OK | F_D | (64'h1 << 50));
    run_walk(1'b0, 1'b1);
    chk(got_fault && log_n == 4, "R5 reserved at leaf faults", 64'(log_n), 64'd4);
    chk(r_code == 4'b1101, "R5 code for reserved user read", 64'(r_code), 64'hD);
    build(F_OK, F_OK | F_PS, F_OK, F_OK);
    run_walk(1'b1, 1'b1);
    chk(got_fault && log_n == 2, "R5 size bit at second level faults", 64'(log_n), 64'd2);
    chk(r_code == 4'b1111, "R5 code for reserved user write", 64'(r_code), 64'hF);
    build(F_OK, F_OK, F_OK, F_OK);
    mem[ea(FR1, I1)] = mk(40'hABC00, F_OK | F_PS | (64'h1 << 13));
    run_walk(1'b0, 1'b0);
    chk(got_fault && r_code == 4'b1001, "R5 2M leaf low bits reserved", 64'(r_code), 64'h9);
  endtask

  task automatic t_perms;
    build(F_OK, F_P | F_US | F_A, F_P | F_RW | F_A | F_NX, F_OK | F_D | F_G);
    run_walk(1'b0, 1'b0);
    chk(got_fill, "R9 permission walk fills", 64'(got_fill), 64'd1);
    chk(!r_wr && !r_us && r_nx && r_g, "R9 combined permissions",
        {60'd0, r_wr, r_us, r_nx, r_g}, 64'h3);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic_4k();
    t_accessed_update();
    t_dirty();
    t_large();
    t_not_present();
    t_reserved();
    t_perms();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule